// File: doc/BRIEF.md
# Pass-Through Wait-State Sequencer

This block runs the local-side strobes of a bus bridge for an active-mode pass-through transfer. A transfer is announced by an active-low attention input, together with a region number, a direction and a burst flag. The sequencer can issue a one-cycle address strobe. It then runs one or more data phases and marks the completion of each phase with a one-cycle data-transfer strobe. It also controls the output enable of the 32-bit local data bus and multiplexes the latched address or the write data onto it.

Two wait sources decide the length of each data phase. The first is a programmed count of 0 to 7 cycles, taken from a 3-bit field for the transfer's region. The second is an active-low wait input driven by the peripheral. The peripheral wait can hold off the address strobe and stall any data phase. While it is sampled low, the bridge releases the data bus so that another local agent can drive it. Any turnaround cycles that agent needs are left to the peripheral.

Top module: `pt_wait_seq`

## Requirements
- R1: In reset, and in idle, the address strobe `adr_no` and the transfer strobe `xfr_no` are high and `dq_oe_o` is low.
- R2: When address strobes are enabled, `adr_no` is low for exactly one cycle. That cycle directly follows the first clock edge at which `attn_ni` is sampled low and `wait_ni` is sampled high. During it, `dq_oe_o` is high and `dq_o` carries the address latched at that edge.
- R3: While `wait_ni` is sampled low with `attn_ni` low in idle, and address strobes are enabled, no address strobe is issued.
- R4: When address strobes are disabled, no address strobe occurs. The first data phase starts at the edge that samples `attn_ni` low, so with N programmed waits and no peripheral waits, the first `xfr_no` pulse falls in cycle N+1 after that edge. With the address strobe in cycle h, the first pulse falls in cycle h+2+N.
- R5: Region r takes its wait count from bits [3r+2:3r] of `region_waits_i`. The region is the value of `region_i` sampled at the start edge.
- R6: Each data phase lasts exactly N+1 cycles when no peripheral waits occur. Consecutive `xfr_no` pulses in a burst are therefore N+1 cycles apart, and each pulse is exactly one cycle long.
- R7: Each data-phase edge at which `wait_ni` is sampled low delays the current and all later `xfr_no` pulses by one cycle. The programmed count holds during those edges.
- R8: In a write, `dq_oe_o` is low in every cycle that follows an edge in a data phase where `wait_ni` was sampled low. It is high again after the next edge that samples `wait_ni` high.
- R9: In a read, `dq_oe_o` is high only during the address-strobe cycle.
- R10: The phase that completes while `burst_ni` is sampled high is the last one. The number of `xfr_no` pulses equals the burst length, and in the cycle after the last pulse all strobes are high and `dq_oe_o` is low.
- R11: In a write, `dq_o` equals `wdata_i` in every `xfr_no` cycle, and `dq_oe_o` is high there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| attn_ni | input | 1 | Transfer request, active low |
| burst_ni | input | 1 | Low: more phases follow the current one |
| region_i | input | 2 | Region number of the request |
| write_i | input | 1 | 1 = write toward the peripheral |
| adr_en_i | input | 1 | Enables the address phase |
| addr_i | input | 32 | Transfer address |
| wdata_i | input | 32 | Write data for the current phase |
| region_waits_i | input | 12 | Per-region 3-bit programmed wait counts |
| wait_ni | input | 1 | Peripheral wait request, active low |
| adr_no | output | 1 | Address strobe, active low |
| xfr_no | output | 1 | Data-transfer strobe, active low |
| dq_oe_o | output | 1 | Output enable for the data bus |
| dq_o | output | 32 | Data bus value when enabled |

## Verification
The assertions assume three things about the inputs. A request is only raised from idle. `attn_ni` is dropped after the start edge so that it does not retrigger. `burst_ni` is stable around each completion edge. The bench keeps within these assumptions. It holds `attn_ni` low only up to the start edge, and it drives `burst_ni` from the number of transfer strobes already seen, so the burst flag is settled before every completion edge. Peripheral waits are placed only inside the first data phase or before the start edge. Their effect on every later strobe is then a fixed shift that the bench computes directly.

// File: rtl/pt_pkg.sv
package pt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } pt_state_e;
endpackage

// File: rtl/pt_region_sel.sv
module pt_region_sel #(
  parameter int NUM_REGIONS = 4,
  parameter int WAIT_W      = 3,
  localparam int RGN_W      = $clog2(NUM_REGIONS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          capture_i,
  input  logic                          idle_i,
  input  logic [RGN_W-1:0]              region_i,
  input  logic [NUM_REGIONS*WAIT_W-1:0] region_waits_i,
  output logic [WAIT_W-1:0]             wait_cnt_o
);
  logic [WAIT_W-1:0] field [NUM_REGIONS];
  logic [RGN_W-1:0]  region_q;
  logic [RGN_W-1:0]  region_sel;

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_field
    assign field[r] = region_waits_i[r*WAIT_W +: WAIT_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) region_q <= '0;
    else if (capture_i) region_q <= region_i;
  end

  // start edge loads from the live region, later phases from the latched one
  assign region_sel = idle_i ? region_i : region_q;
  assign wait_cnt_o = field[region_sel];
endmodule

// File: rtl/pt_wait_cnt.sv
module pt_wait_cnt #(
  parameter int WAIT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WAIT_W-1:0] load_val_i,
  input  logic              run_i,
  input  logic              wait_ni,
  output logic              zero_o
);
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (run_i && wait_ni && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R6
  cnt_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && run_i && wait_ni && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R7
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !wait_ni) |=> $stable(cnt_q));
endmodule

// File: rtl/pt_phase_fsm.sv
module pt_phase_fsm
  import pt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic attn_ni,
  input  logic burst_ni,
  input  logic wait_ni,
  input  logic adr_en_i,
  input  logic write_i,
  input  logic cnt_zero_i,
  output logic start_o,
  output logic idle_o,
  output logic load_o,
  output logic run_o,
  output logic adr_no,
  output logic xfr_no,
  output logic dq_oe_o
);
  pt_state_e state_q, state_d;
  logic write_q, wr_eff;
  logic go_adr, go_direct, complete, last;

  assign idle_o    = (state_q == ST_IDLE);
  assign start_o   = idle_o && !attn_ni;
  assign go_adr    = start_o && adr_en_i && wait_ni;
  assign go_direct = start_o && !adr_en_i;
  assign complete  = (state_q == ST_DATA) && wait_ni && cnt_zero_i;
  assign last      = complete && burst_ni;
  assign run_o     = (state_q == ST_DATA);
  assign load_o    = go_direct || (state_q == ST_ADDR) || (complete && !burst_ni);
  assign wr_eff    = idle_o ? write_i : write_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (go_adr)         state_d = ST_ADDR;
        else if (go_direct) state_d = ST_DATA;
      end
      ST_ADDR: state_d = ST_DATA;
      ST_DATA: if (last) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      write_q <= 1'b0;
      adr_no  <= 1'b1;
      xfr_no  <= 1'b1;
      dq_oe_o <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_o) write_q <= write_i;
      adr_no  <= !(state_d == ST_ADDR);
      xfr_no  <= !complete;
      // bus released the cycle after a low wait sample
      dq_oe_o <= (state_d == ST_ADDR) ||
                 (wr_eff && wait_ni && ((state_d == ST_DATA) || complete));
    end
  end

  // R2
  adr_needs_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adr_no |-> dq_oe_o);
  // R2
  adr_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(adr_no) |-> ($past(wait_ni) && !$past(attn_ni)));
  // R2
  adr_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adr_no |=> adr_no);
  // R6
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!adr_no && !xfr_no));
  // R7
  xfr_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(xfr_no) |-> $past(wait_ni));
  // R8
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA && !wait_ni) |=> !dq_oe_o);
  // R10
  last_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last |=> (state_q == ST_IDLE && !xfr_no));
endmodule

// File: rtl/pt_wait_seq.sv
module pt_wait_seq #(
  parameter int NUM_REGIONS = 4,
  parameter int WAIT_W      = 3,
  parameter int DATA_W      = 32,
  localparam int RGN_W      = $clog2(NUM_REGIONS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          attn_ni,
  input  logic                          burst_ni,
  input  logic [RGN_W-1:0]              region_i,
  input  logic                          write_i,
  input  logic                          adr_en_i,
  input  logic [DATA_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  input  logic [NUM_REGIONS*WAIT_W-1:0] region_waits_i,
  input  logic                          wait_ni,
  output logic                          adr_no,
  output logic                          xfr_no,
  output logic                          dq_oe_o,
  output logic [DATA_W-1:0]             dq_o
);
  logic              start, idle, load, run, cnt_zero;
  logic [WAIT_W-1:0] wait_cnt;
  logic [DATA_W-1:0] addr_q;

  pt_region_sel #(.NUM_REGIONS(NUM_REGIONS), .WAIT_W(WAIT_W)) u_rsel (
    .clk_i, .rst_ni,
    .capture_i      (start),
    .idle_i         (idle),
    .region_i,
    .region_waits_i,
    .wait_cnt_o     (wait_cnt)
  );

  pt_wait_cnt #(.WAIT_W(WAIT_W)) u_cnt (
    .clk_i, .rst_ni,
    .load_i     (load),
    .load_val_i (wait_cnt),
    .run_i      (run),
    .wait_ni,
    .zero_o     (cnt_zero)
  );

  pt_phase_fsm u_fsm (
    .clk_i, .rst_ni, .attn_ni, .burst_ni, .wait_ni, .adr_en_i, .write_i,
    .cnt_zero_i (cnt_zero),
    .start_o    (start),
    .idle_o     (idle),
    .load_o     (load),
    .run_o      (run),
    .adr_no, .xfr_no, .dq_oe_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else if (start) addr_q <= addr_i;
  end

  assign dq_o = adr_no ? wdata_i : addr_q;

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && xfr_no) |-> (adr_no && !dq_oe_o));
endmodule

// File: tb/pt_wait_seq_tb_top.sv
module pt_wait_seq_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        attn_ni = 1'b1, burst_ni = 1'b1, write_i = 1'b0, adr_en_i = 1'b0;
  logic        wait_ni = 1'b1;
  logic [1:0]  region_i = '0;
  logic [31:0] addr_i = '0, wdata_i = '0;
  logic [11:0] region_waits_i = '0;
  logic        adr_no, xfr_no, dq_oe_o;
  logic [31:0] dq_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  pt_wait_seq dut_i (
    .clk_i, .rst_ni, .attn_ni, .burst_ni, .region_i, .write_i, .adr_en_i,
    .addr_i, .wdata_i, .region_waits_i, .wait_ni,
    .adr_no, .xfr_no, .dq_oe_o, .dq_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // one transfer: n waits, burst length l, address hold h, peripheral wait wl cycles at offset off
  task automatic run_xfer(input int rg, input int n, input int l, input bit adr, input bit wr,
                          input int h, input int off, input int wl);
    int base, first, last_s, ws, seen, nadr, last_k;
    base   = adr ? h + 2 : 1;
    first  = base + n + wl;
    last_s = first + (l - 1) * (n + 1);
    ws     = base + off;
    seen = 0; nadr = 0;
    last_k = last_s + 3;
    for (int r = 0; r < 4; r++)
      region_waits_i[r*3 +: 3] = 3'((r == rg) ? n : (n + r + 1) % 8);
    region_i = 2'(rg); write_i = wr; adr_en_i = adr;
    addr_i  = 32'hA000_0000 + 32'(rg * 256 + n * 16 + l);
    wdata_i = 32'h5A00_0000 ^ 32'(n * 4099 + l);
    // drive for edge 0
    attn_ni  = 1'b0;
    burst_ni = (l > 1) ? 1'b0 : 1'b1;
    wait_ni  = !(h > 0 && adr);
    for (int k = 0; k <= last_k; k++) begin
      bit exp_xfr, exp_oe, exp_adr, in_wait;
      @(posedge clk_i);
      @(negedge clk_i);
      in_wait = (wl > 0) && k >= ws && k < ws + wl;
      exp_adr = adr && k == h;
      exp_xfr = (k >= first) && (k <= last_s) && ((k - first) % (n + 1) == 0);
      if (wr) exp_oe = (k >= (adr ? h : 0)) && (k <= last_s) && !in_wait;
      else    exp_oe = exp_adr;
      if (adr && k < h) chk("R3 held-off address strobe", 32'(adr_no), 32'd1);
      else if (adr) chk("R2 address strobe", 32'(adr_no), 32'(!exp_adr));
      else chk("R4 no address strobe", 32'(adr_no), 32'd1);
      if (k < first) chk(adr ? "R4 first strobe timing" : "R4 direct first strobe", 32'(xfr_no), 32'(!exp_xfr));
      else if (wl > 0) chk("R7 wait-shifted strobe", 32'(xfr_no), 32'(!exp_xfr));
      else chk("R6 phase spacing R5 region field", 32'(xfr_no), 32'(!exp_xfr));
      if (in_wait && wr) chk("R8 bus released", 32'(dq_oe_o), 32'd0);
      else if (wr) chk("R8 output enable", 32'(dq_oe_o), 32'(exp_oe));
      else chk("R9 read enable", 32'(dq_oe_o), 32'(exp_oe));
      if (exp_adr) chk("R2 address on bus", dq_o, addr_i);
      if (exp_xfr && wr) chk("R11 write data", dq_o, wdata_i);
      if (k > last_s) begin
        chk("R10 idle after last", 32'({adr_no, xfr_no, dq_oe_o}), 32'b110);
        chk("R1 idle state", 32'({adr_no, xfr_no, dq_oe_o}), 32'b110);
      end
      if (!xfr_no) seen++;
      if (!adr_no) nadr++;
      // drive for edge k+1
      attn_ni  = !(adr && (k + 1) <= h);
      burst_ni = (seen < l - 1) ? 1'b0 : 1'b1;
      wait_ni  = !((adr && (k + 1) < h) || (wl > 0 && (k + 1) >= ws && (k + 1) < ws + wl));
    end
    chk("R10 strobe count", 32'(seen), 32'(l));
    chk("R2 address strobe count", 32'(nadr), 32'(adr ? 1 : 0));
    attn_ni = 1'b1; wait_ni = 1'b1; burst_ni = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset strobes", 32'({adr_no, xfr_no, dq_oe_o}), 32'b110);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 idle after reset", 32'({adr_no, xfr_no, dq_oe_o}), 32'b110);
    for (int rg = 0; rg < 4; rg++)
      for (int n = 0; n < 8; n++)
        for (int v = 0; v < 16; v++) begin
          int l, h, wl;
          bit adr, wr;
          l   = (v[0]) ? 3 : 1;
          adr = v[1];
          wr  = v[2];
          h   = (v[3] && adr) ? 2 : 0;
          wl  = v[3] ? 2 : 0;
          run_xfer(rg, n, l, adr, wr, h, (n + rg) % (n + 1), wl);
          @(negedge clk_i);
        end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule